// File: doc/BRIEF.md
# Claim/Complete Interrupt Controller

This block gathers level-sensitive interrupt lines from peripherals and turns them into one request line per target context. A context here is one privilege level of one processor; the default build has a machine-level context and a supervisor-level context. Each source has a small priority value, and each context has a threshold and its own enable bits. A context's request line is high while at least one source qualifies for it. A source qualifies when it is pending, enabled for that context, not currently being serviced, and its priority is above that context's threshold.

Software works through a 32-bit register bus that accepts only aligned word accesses. To service an interrupt, the handler reads its context's claim register. That read returns the best qualifying source ID and, in the same cycle, marks the source as claimed. A claimed source is hidden from every context. When the handler is done, it writes the ID back to the same register. That completion write releases the source, which can then be selected again if its line is still high.

Priority and threshold writes are filtered so that only legal values are ever stored. When the number of priority levels is a power of two, extra high bits are discarded. Otherwise an out-of-range write is dropped.

Top module: `irq_claim_ctrl`

## Requirements
- R1: Reset clears every priority, threshold, enable, pending and claimed bit. It drives `irq_o` low. After reset, every register reads 0, and a claim read returns 0.
- R2: Source n's priority is at byte address 0x000 + 4*n. With the default 8 levels, the stored value is the written value modulo 8. If the level count is not a power of two, a write above the largest level is dropped and the old value is kept.
- R3: Context c's threshold is at 0x400 + 0x10*c + 0x0. Its writes are filtered by the same rule as R2.
- R4: The pending word at 0x100 shows the source levels sampled one clock earlier. Bit n belongs to source n, and bit 0 always reads 0. Writes to this address change nothing.
- R5: Context c's enable word is at 0x200 + 0x10*c. Bit n enables source n and reads back as written. Offsets 0x4 to 0xC within the stride read 0 and ignore writes.
- R6: Within a context stride, offsets other than 0x0 and 0x4 read 0 and ignore writes. So does any address outside the four windows.
- R7: `irq_o[c]` is high exactly when some source other than 0 is pending, enabled for c, unclaimed, and has a priority strictly above c's threshold.
- R8: A read of context c's claim register at 0x400 + 0x10*c + 0x4 returns the qualifying source with the highest priority. Among equal priorities, the lowest ID wins. The read returns 0 when no source qualifies.
- R9: A claim read that returns a nonzero ID marks that source claimed. From the next cycle on, the source is excluded for every context, and `irq_o` reflects the exclusion.
- R10: Writing an ID below the source count to a claim register releases that source. Writing an ID at or above the source count changes nothing.
- R11: Read data appears on `bus_rdata` in the cycle after the request. Write effects are visible in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive source lines, bit n = source n |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, low two bits zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 2 | Request line per context |

## Verification
Every result of this block is due one clock edge after its cause. Source levels reach the pending word one edge after they change. Read data and the claimed bit set by a claim both land on the edge that takes the read. Priority, threshold, enable and completion writes move `irq_o` on the edge that takes the write. The bench drives each input at a falling edge and samples at the next falling edge, so exactly one rising edge lies between cause and check. It compares every claim ID and request line against a model it keeps from the requirements.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC    = 32;
    localparam int NUM_CTX    = 2;
    localparam int MAX_PRIO   = 7;
    localparam int ADDR_W     = 12;

    localparam int PRIO_BASE  = 'h000;
    localparam int PEND_BASE  = 'h100;
    localparam int EN_BASE    = 'h200;
    localparam int EN_STRIDE  = 'h10;
    localparam int CTX_BASE   = 'h400;
    localparam int CTX_STRIDE = 'h10;

    localparam int  PRIO_W    = $clog2(MAX_PRIO + 1);
    localparam int  ID_W      = $clog2(NUM_SRC);
    localparam int  CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int  WORDS     = (NUM_SRC + 31) / 32;
    localparam bit  PRIO_POW2 = ((MAX_PRIO + 1) & MAX_PRIO) == 0;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [CTX_W-1:0]  ctx_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_PRIO, RG_PEND, RG_EN, RG_THR, RG_CLAIM
    } region_t;

    typedef struct packed {
        region_t     rg;
        logic [15:0] idx;
        logic [15:0] ctx;
        logic [15:0] word;
    } dec_t;

    typedef struct packed {
        logic  ok;
        prio_t val;
    } legal_t;

    // Legalise a priority or threshold write value.
    function automatic legal_t legalise(input logic [31:0] v);
        legal_t r;
        r.ok  = PRIO_POW2 || (v <= 32'(MAX_PRIO));
        r.val = PRIO_POW2 ? prio_t'(v % 32'(MAX_PRIO + 1)) : prio_t'(v);
        return r;
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        int   ai;
        int   rel;
        int   w;
        ai     = int'(a);
        d      = '0;
        d.rg   = RG_NONE;
        if (ai >= PRIO_BASE && ai < PRIO_BASE + 4 * NUM_SRC) begin
            d.rg  = RG_PRIO;
            d.idx = 16'((ai - PRIO_BASE) / 4);
        end else if (ai >= PEND_BASE && ai < PEND_BASE + 4 * WORDS) begin
            d.rg   = RG_PEND;
            d.word = 16'((ai - PEND_BASE) / 4);
        end else if (ai >= EN_BASE && ai < EN_BASE + NUM_CTX * EN_STRIDE) begin
            rel   = ai - EN_BASE;
            w     = (rel % EN_STRIDE) / 4;
            d.ctx = 16'(rel / EN_STRIDE);
            if (w < WORDS) begin
                d.rg   = RG_EN;
                d.word = 16'(w);
            end
        end else if (ai >= CTX_BASE && ai < CTX_BASE + NUM_CTX * CTX_STRIDE) begin
            rel   = ai - CTX_BASE;
            d.ctx = 16'(rel / CTX_STRIDE);
            if (rel % CTX_STRIDE == 0)      d.rg = RG_THR;
            else if (rel % CTX_STRIDE == 4) d.rg = RG_CLAIM;
        end
        return d;
    endfunction

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] take_i,
    input  logic [NUM_SRC-1:0] done_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] clm_o
);

    localparam logic [NUM_SRC-1:0] NO_SRC0 = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            clm_q  <= '0;
        end else begin
            pend_q <= src_i & ~take_i & NO_SRC0;
            clm_q  <= (clm_q | take_i) & ~done_i & NO_SRC0;
        end
    end

    assign pend_o = pend_q;
    assign clm_o  = clm_q;

endmodule

// File: rtl/irqc_select.sv
module irqc_select
    import irqc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        elig_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  prio_t                     thr_i,
    output id_t                       id_o,
    output logic                      req_o
);

    prio_t best;

    always_comb begin
        id_o = '0;
        best = thr_i;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (elig_i[i] && prio_i[i*PRIO_W +: PRIO_W] > best) begin
                id_o = id_t'(i);
                best = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
        req_o = (id_o != '0);
    end

    // R7
    sel_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (elig_i[id_o] && prio_i[int'(id_o)*PRIO_W +: PRIO_W] > thr_i));

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] irq_o
);

    prio_t              prio_q [NUM_SRC];
    prio_t              thr_q  [NUM_CTX];
    logic [NUM_SRC-1:0] en_q   [NUM_CTX];
    logic [31:0]        rdata_q;

    logic [NUM_SRC-1:0]        pend, clm, take, done;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    id_t                       win_id [NUM_CTX];

    dec_t   dec;
    ctx_t   ctx;
    logic   rd, wr, claim_hit, claim_fire, done_fire;
    id_t    claim_id;
    legal_t lw;
    logic [WORDS*32-1:0] pend_wide, en_wide;
    logic [31:0]         rd_val;

    assign dec = decode(bus_addr);
    assign ctx = ctx_t'(dec.ctx);
    assign rd  = bus_req && !bus_we;
    assign wr  = bus_req && bus_we;
    assign lw  = legalise(bus_wdata);

    assign claim_hit  = rd && dec.rg == RG_CLAIM;
    assign claim_id   = win_id[ctx];
    assign claim_fire = claim_hit && claim_id != '0;
    assign done_fire  = wr && dec.rg == RG_CLAIM && bus_wdata < 32'(NUM_SRC);

    always_comb begin
        take = '0;
        done = '0;
        if (claim_fire) take[claim_id] = 1'b1;
        if (done_fire)  done[bus_wdata[ID_W-1:0]] = 1'b1;
    end

    irqc_gateway u_gate (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .take_i (take),
        .done_i (done),
        .pend_o (pend),
        .clm_o  (clm)
    );

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
            assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
        end
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            irqc_select u_sel (
                .clk    (clk),
                .rst    (rst),
                .elig_i (pend & ~clm & en_q[c]),
                .prio_i (prio_flat),
                .thr_i  (thr_q[c]),
                .id_o   (win_id[c]),
                .req_o  (irq_o[c])
            );
        end
    endgenerate

    // Word views of the pending and enable vectors.
    always_comb begin
        pend_wide              = '0;
        pend_wide[NUM_SRC-1:0] = pend;
        en_wide                = '0;
        en_wide[NUM_SRC-1:0]   = en_q[ctx];
        rd_val                 = '0;
        case (dec.rg)
            RG_PRIO:  rd_val = 32'(prio_q[id_t'(dec.idx)]);
            RG_PEND:  rd_val = pend_wide[32*int'(dec.word) +: 32];
            RG_EN:    rd_val = en_wide[32*int'(dec.word) +: 32];
            RG_THR:   rd_val = 32'(thr_q[ctx]);
            RG_CLAIM: rd_val = 32'(claim_id);
            default:  rd_val = '0;
        endcase
        en_wide[32*int'(dec.word) +: 32] = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                thr_q[c] <= '0;
                en_q[c]  <= '0;
            end
        end else begin
            if (rd) rdata_q <= rd_val;
            if (wr) begin
                case (dec.rg)
                    RG_PRIO: if (lw.ok) prio_q[id_t'(dec.idx)] <= lw.val;
                    RG_THR:  if (lw.ok) thr_q[ctx] <= lw.val;
                    RG_EN:   en_q[ctx] <= en_wide[NUM_SRC-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq_o == '0));

    // R9
    claim_marks_chk: assert property (@(posedge clk) disable iff (rst)
        claim_fire |=> clm[$past(claim_id)]);

    // R10
    complete_frees_chk: assert property (@(posedge clk) disable iff (rst)
        done_fire |=> !clm[$past(bus_wdata[ID_W-1:0])]);

    // R8
    claim_data_chk: assert property (@(posedge clk) disable iff (rst)
        claim_hit |=> (bus_rdata[31:ID_W] == '0));

endmodule

// File: tb/irq_claim_ctrl_test.sv
module irq_claim_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src_i;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    int          m_prio [NS];
    int          m_thr  [2];
    logic [31:0] m_en   [2];
    logic [31:0] m_clm;
    logic [31:0] m_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_claim_ctrl uut (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v; m_src = v;
        @(negedge clk);
    endtask

    function automatic int winner(input int c);
        int best = 0;
        int bp   = m_thr[c];
        for (int i = 1; i < NS; i++)
            if (m_src[i] && m_en[c][i] && !m_clm[i] && m_prio[i] > bp) begin
                best = i; bp = m_prio[i];
            end
        return best;
    endfunction

    task automatic chk_irq(input string tag);
        for (int c = 0; c < 2; c++)
            chk(tag, 32'(irq_o[c]), 32'(winner(c) != 0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int          exp_id;
        rst = 1'b1; src_i = '0; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        m_clm = '0; m_src = '0;
        for (int i = 0; i < NS; i++) m_prio[i] = 0;
        for (int c = 0; c < 2; c++) begin m_thr[c] = 0; m_en[c] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        bus_rd(12'h014, rv); chk("R1 prio", rv, 0);
        bus_rd(12'h410, rv); chk("R1 thr", rv, 0);
        bus_rd(12'h200, rv); chk("R1 enable", rv, 0);
        bus_rd(12'h100, rv); chk("R1 pending", rv, 0);
        bus_rd(12'h404, rv); chk("R1 claim", rv, 0);

        // R2 priority sweep with modulo legalisation, R11 one-cycle read
        for (int n = 0; n < NS; n++) begin
            bus_wr(12'(4 * n), 32'(n * 11 + 5));
            m_prio[n] = (n * 11 + 5) % 8;
            bus_rd(12'(4 * n), rv);
            chk("R2 prio legal", rv, 32'(m_prio[n]));
        end

        // R3 threshold legalisation
        for (int c = 0; c < 2; c++) begin
            bus_wr(12'(12'h400 + 16 * c), 32'd13);
            bus_rd(12'(12'h400 + 16 * c), rv);
            chk("R3 thr legal", rv, 32'd5);
            bus_wr(12'(12'h400 + 16 * c), 32'd0);
        end

        // R4 pending follows levels, bit 0 zero, writes ignored
        set_src(32'hA5A5_0F0F);
        bus_rd(12'h100, rv); chk("R4 pending", rv, 32'hA5A5_0F0E);
        bus_wr(12'h100, 32'h0000_0000);
        bus_rd(12'h100, rv); chk("R4 pending ro", rv, 32'hA5A5_0F0E);
        set_src(32'h1234_5679);
        bus_rd(12'h100, rv); chk("R4 pending 2", rv, 32'h1234_5678);

        // R5 enable words and unused word offsets
        bus_wr(12'h200, 32'hFFFF_FFFF); m_en[0] = 32'hFFFF_FFFF;
        bus_wr(12'h210, 32'h0000_F0F0); m_en[1] = 32'h0000_F0F0;
        bus_rd(12'h200, rv); chk("R5 en ctx0", rv, 32'hFFFF_FFFF);
        bus_rd(12'h210, rv); chk("R5 en ctx1", rv, 32'h0000_F0F0);
        bus_wr(12'h214, 32'hFFFF_FFFF);
        bus_rd(12'h214, rv); chk("R5 en spare word", rv, 0);
        bus_rd(12'h210, rv); chk("R5 en ctx1 kept", rv, 32'h0000_F0F0);

        // R6 other context offsets and unmapped space
        bus_wr(12'h408, 32'hFFFF_FFFF);
        bus_rd(12'h408, rv); chk("R6 ctx spare", rv, 0);
        bus_wr(12'hF00, 32'h0000_0003);
        bus_rd(12'hF00, rv); chk("R6 unmapped", rv, 0);
        bus_rd(12'h000, rv); chk("R6 prio kept", rv, 32'(m_prio[0]));
        bus_rd(12'h400, rv); chk("R6 thr kept", rv, 0);

        // R7 R8 R9 claim sweep, all sources high
        set_src(32'hFFFF_FFFE);
        chk_irq("R7 irq all high");
        for (int k = 0; k < NS + 1; k++) begin
            exp_id = winner(0);
            bus_rd(12'h404, rv);
            chk("R8 claim id", rv, 32'(exp_id));
            if (exp_id != 0) m_clm[exp_id] = 1'b1;
            chk_irq("R9 irq after claim");
        end

        // R10 out-of-range completion ignored
        bus_wr(12'h404, 32'd32);
        bus_rd(12'h404, rv); chk("R10 big id ignored", rv, 0);

        // R10 completion sweep via context 1
        for (int n = NS - 1; n >= 1; n--) begin
            bus_wr(12'h414, 32'(n));
            m_clm[n] = 1'b0;
            chk_irq("R10 irq after complete");
        end

        // R7 threshold masking
        for (int t = 0; t < 8; t++) begin
            bus_wr(12'h400, 32'(t)); m_thr[0] = t;
            chk_irq("R7 thr sweep");
            exp_id = winner(0);
            bus_rd(12'h404, rv); chk("R8 claim thr", rv, 32'(exp_id));
            if (exp_id != 0) begin
                m_clm[exp_id] = 1'b1;
                bus_wr(12'h404, 32'(exp_id)); m_clm[exp_id] = 1'b0;
            end
        end

        // R7 level low removes requests
        bus_wr(12'h400, 32'd0); m_thr[0] = 0;
        set_src(32'h0000_0000);
        chk_irq("R7 levels low");
        bus_rd(12'h404, rv); chk("R8 claim none", rv, 0);

        // R1 reset in mid-run
        set_src(32'h0000_00F0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; m_src = 32'h0000_00F0;
        chk("R1 irq after reset", 32'(irq_o), 0);
        bus_rd(12'h01C, rv); chk("R1 prio after reset", rv, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule